// File: doc/BRIEF.md
# Network Controller Run-Control and Init-Address Registers

This block is the register front end of a bus-mastering network controller. It holds three run-control bits: halt, run and initialize. Software sets each of them by writing a one, and setting one of them clears the bits that conflict with it. The block also holds the 32-bit address of the initialization block in two 16-bit registers. It raises an initialization request toward the fetch engine until that engine reports completion. It gives the datapath a start-enable output, which is held back until a pending initialization has finished.

The two address registers can be written only while the controller is halted or the suspend input is high. Resets and halting leave them unchanged. When the structure-width input is low, the controller runs with 24-bit software structures. In that mode the block widens every 24-bit pointer lane to 32 bits by putting the stored address bits 31:24 in front of it. When that input is high, pointers pass through unchanged.

Top module: `netctl_csr_front`

## Requirements
- R1: After a hard reset (rst_n low) or a one-cycle soft_rst pulse, halt is set and run, initialize, init_req and start_en are low. The control register at offset 0 reads initialize in bit 0, run in bit 1 and halt in bit 2, with bits 31:3 reading zero.
- R2: Writing a one to control bit 2 sets halt and clears run and initialize. When bit 2 is written together with bit 0 or bit 1, halt wins.
- R3: A write of zero to any control bit leaves that bit unchanged.
- R4: Setting run (bit 1) or initialize (bit 0) clears halt.
- R5: While initialize is set and no completion has been seen, init_req is high. A cycle with init_req and init_done both high drops init_req from the next cycle. Initialize stays set after completion. Writing initialize again starts a new request.
- R6: start_en rises in the cycle after run is set, provided no initialization is pending. When run and initialize are written together, start_en stays low until init_done has been accepted and rises in the next cycle.
- R7: The address registers at offset 1 (bits 15:0) and offset 2 (bits 31:16) accept writes only while halt is set or spnd is high. At other times a write is ignored.
- R8: Hard reset, soft reset and setting halt leave both address registers unchanged.
- R9: Offset 1 reads the written bits 15:2 with bits 1:0 forced to zero. Offset 2 reads the written bits 15:0. Register bits 31:16 and all of offset 3 read zero. init_addr always equals {offset 2, offset 1}.
- R10: With struct32 low, each 32-bit pointer lane leaves as {stored address bits 31:24, lane bits 23:0}. With struct32 high, each lane leaves unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| spnd | input | 1 | Suspend indication; unlocks the address registers |
| struct32 | input | 1 | 1: 32-bit structures, 0: 24-bit structures |
| init_done | input | 1 | Initialization fetch complete |
| init_req | output | 1 | Initialization requested |
| start_en | output | 1 | Transmit and receive enabled |
| init_addr | output | 32 | Initialization block address |
| ptr_in | input | NPTR*32 | Pointer lanes from the descriptor and buffer logic |
| ptr_out | output | NPTR*32 | Widened pointer lanes |

## Verification
The bench builds the block with NPTR set to 3, one lane above the default. This runs the generated widening logic on more than two lanes, each fed independent random pointers, so a lane that is wired wrong shows up. The control and address widths stay at their fixed 32-bit values. At those widths the reserved upper halves and the forced-zero alignment bits can be seen on every readback.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
    localparam int REG_W  = 32;
    localparam int HALF_W = 16;
    localparam int PTR_W  = 32;
    localparam int LOW_W  = 24;
    localparam int ALIGN_W = 2;

    localparam int B_INIT = 0;
    localparam int B_RUN  = 1;
    localparam int B_HALT = 2;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_ADLO = 2'd1,
        RA_ADHI = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic halt;
        logic run;
        logic init;
        logic done;
    } runctl_t;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } iadr_t;

    localparam runctl_t RUNCTL_RST = '{halt: 1'b1, run: 1'b0, init: 1'b0, done: 1'b0};
endpackage

// File: rtl/ncr_runctl.sv
module ncr_runctl
    import ncr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic wr,
    input  logic set_init,
    input  logic set_run,
    input  logic set_halt,
    input  logic init_done,
    output logic halt,
    output logic run,
    output logic init,
    output logic init_req,
    output logic start_en
);
    runctl_t q, d;

    always_comb begin
        d = q;
        if (q.init && !q.done && init_done) begin
            d.done = 1'b1;
        end
        if (wr) begin
            if (set_halt) begin
                d.halt = 1'b1;
                d.run  = 1'b0;
                d.init = 1'b0;
                d.done = 1'b0;
            end else begin
                if (set_init) begin
                    d.init = 1'b1;
                    d.halt = 1'b0;
                    d.done = 1'b0;
                end
                if (set_run) begin
                    d.run  = 1'b1;
                    d.halt = 1'b0;
                end
            end
        end
        if (soft_rst) begin
            d = RUNCTL_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RUNCTL_RST;
        else        q <= d;
    end

    assign halt     = q.halt;
    assign run      = q.run;
    assign init     = q.init;
    assign init_req = q.init && !q.done;
    assign start_en = q.run && (!q.init || q.done);

    // R1: soft reset returns to the halted state
    a_r1_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (halt && !run && !init && !init_req && !start_en));

    // R2: halt write wins and clears run and initialize
    a_r2_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && set_halt && !soft_rst) |=> (halt && !run && !init));

    // R3: an all-zero control write changes nothing
    a_r3_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !set_halt && !set_run && !set_init && !soft_rst)
        |=> ($stable(halt) && $stable(run) && $stable(init)));

    // R4: setting run or initialize clears halt
    a_r4_set_clears_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !set_halt && (set_run || set_init) && !soft_rst) |=> !halt);

    // R5: accepted completion drops the request but keeps initialize
    a_r5_done_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_done && !wr && !soft_rst) |=> (!init_req && init));

    // R6: run alone with nothing pending enables at once
    a_r6_run_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && set_run && !set_init && !set_halt && !init && !soft_rst) |=> start_en);

    // R6: never enabled while a request is outstanding
    a_r6_wait_init: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |-> !start_en);
endmodule

// File: rtl/ncr_iadr.sv
module ncr_iadr
    import ncr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] lo,
    output logic [HALF_W-1:0] hi
);
    iadr_t q, d;

    always_comb begin
        d = q;
        if (unlock && wr_lo) d.lo = {wdata[HALF_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
        if (unlock && wr_hi) d.hi = wdata;
    end

    // No reset by design: contents survive hard and soft reset
    always_ff @(posedge clk) begin
        q <= d;
    end

    assign lo = q.lo;
    assign hi = q.hi;

    // R7: locked writes are ignored
    a_r7_lock_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !unlock) |=> $stable(lo));
    a_r7_lock_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !unlock) |=> $stable(hi));
    // R8: without a write the contents hold
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> ($stable(lo) && $stable(hi)));
endmodule

// File: rtl/ncr_ptr_xlate.sv
module ncr_ptr_xlate
    import ncr_pkg::*;
#(
    parameter int NPTR = 2
) (
    input  logic                  struct32,
    input  logic [7:0]            top_byte,
    input  logic [NPTR*PTR_W-1:0] ptr_in,
    output logic [NPTR*PTR_W-1:0] ptr_out
);
    for (genvar g = 0; g < NPTR; g++) begin : g_lane
        logic [PTR_W-1:0] lane_in, lane_d;
        assign lane_in = ptr_in[g*PTR_W +: PTR_W];
        always_comb begin
            lane_d = lane_in;
            if (!struct32) lane_d = {top_byte, lane_in[LOW_W-1:0]};
        end
        assign ptr_out[g*PTR_W +: PTR_W] = lane_d;
    end
endmodule

// File: rtl/netctl_csr_front.sv
module netctl_csr_front
    import ncr_pkg::*;
#(
    parameter int NPTR = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  soft_rst,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    input  logic                  spnd,
    input  logic                  struct32,
    input  logic                  init_done,
    output logic                  init_req,
    output logic                  start_en,
    output logic [PTR_W-1:0]      init_addr,
    input  logic [NPTR*PTR_W-1:0] ptr_in,
    output logic [NPTR*PTR_W-1:0] ptr_out
);
    reg_addr_e ra;
    logic wr_ctrl, wr_lo, wr_hi;
    logic halt, run, init;
    logic [HALF_W-1:0] adr_lo, adr_hi;
    logic unused_rsvd;

    assign ra      = reg_addr_e'(reg_addr);
    assign wr_ctrl = reg_wr && (ra == RA_CTRL);
    assign wr_lo   = reg_wr && (ra == RA_ADLO);
    assign wr_hi   = reg_wr && (ra == RA_ADHI);
    assign unused_rsvd = ^reg_wdata[REG_W-1:HALF_W];

    ncr_runctl u_runctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr       (wr_ctrl),
        .set_init (reg_wdata[B_INIT]),
        .set_run  (reg_wdata[B_RUN]),
        .set_halt (reg_wdata[B_HALT]),
        .init_done(init_done),
        .halt     (halt),
        .run      (run),
        .init     (init),
        .init_req (init_req),
        .start_en (start_en)
    );

    ncr_iadr u_iadr (
        .clk   (clk),
        .rst_n (rst_n),
        .unlock(halt || spnd),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi),
        .wdata (reg_wdata[HALF_W-1:0]),
        .lo    (adr_lo),
        .hi    (adr_hi)
    );

    ncr_ptr_xlate #(.NPTR(NPTR)) u_xlate (
        .struct32(struct32),
        .top_byte(adr_hi[HALF_W-1:HALF_W-8]),
        .ptr_in  (ptr_in),
        .ptr_out (ptr_out)
    );

    assign init_addr = {adr_hi, adr_lo};

    always_comb begin
        reg_rdata = '0;
        unique case (ra)
            RA_CTRL: begin
                reg_rdata[B_INIT] = init;
                reg_rdata[B_RUN]  = run;
                reg_rdata[B_HALT] = halt;
            end
            RA_ADLO: reg_rdata[HALF_W-1:0] = adr_lo;
            RA_ADHI: reg_rdata[HALF_W-1:0] = adr_hi;
            default: reg_rdata = '0;
        endcase
    end

    // R10: 24-bit mode takes the top byte from the stored address
    a_r10_widen: assert property (@(posedge clk) disable iff (!rst_n)
        !struct32 |-> (ptr_out[PTR_W-1:LOW_W] == init_addr[PTR_W-1:LOW_W]));
    // R9: alignment bits of the init address stay zero
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_lo) |-> (init_addr[ALIGN_W-1:0] == '0));
endmodule

// File: tb/netctl_csr_front_test.sv
`timescale 1ns/1ps
module netctl_csr_front_test;
    localparam int NP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic spnd = 1'b0;
    logic struct32 = 1'b0;
    logic init_done = 1'b0;
    logic init_req, start_en;
    logic [31:0] init_addr;
    logic [NP*32-1:0] ptr_in = '0;
    logic [NP*32-1:0] ptr_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // model state
    bit mhalt, mrun, minit, mdone;
    logic [15:0] mlo, mhi;

    always #10 clk = ~clk;

    netctl_csr_front #(.NPTR(NP)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spnd(spnd), .struct32(struct32), .init_done(init_done),
        .init_req(init_req), .start_en(start_en), .init_addr(init_addr),
        .ptr_in(ptr_in), .ptr_out(ptr_out)
    );

    function automatic logic [31:0] exp_ctrl();
        return {29'd0, mhalt, mrun, minit};
    endfunction

    function automatic logic [31:0] exp_lane(logic [31:0] p);
        return struct32 ? p : {mhi[15:8], p[23:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(string tag, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic check_all(string tag);
        read_chk({tag, " R1 ctrl"}, 2'd0, exp_ctrl());
        read_chk({tag, " R9 lo"}, 2'd1, {16'd0, mlo});
        read_chk({tag, " R9 hi"}, 2'd2, {16'd0, mhi});
        read_chk({tag, " R9 off3"}, 2'd3, 32'd0);
        check({tag, " R5 init_req"}, {31'd0, init_req}, {31'd0, minit && !mdone});
        check({tag, " R6 start_en"}, {31'd0, start_en}, {31'd0, mrun && (!minit || mdone)});
        check({tag, " R9 init_addr"}, init_addr, {mhi, mlo});
        for (int i = 0; i < NP; i++)
            check({tag, " R10 lane"}, ptr_out[i*32 +: 32], exp_lane(ptr_in[i*32 +: 32]));
    endtask

    task automatic model_reset();
        mhalt = 1; mrun = 0; minit = 0; mdone = 0;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        bit unlock;
        @(negedge clk);
        unlock = mhalt || spnd;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) begin
            if (d[2]) begin
                mhalt = 1; mrun = 0; minit = 0; mdone = 0;
            end else begin
                if (d[0]) begin minit = 1; mhalt = 0; mdone = 0; end
                if (d[1]) begin mrun = 1; mhalt = 0; end
            end
        end else if (a == 2'd1 && unlock) mlo = {d[15:2], 2'b00};
        else if (a == 2'd2 && unlock) mhi = d[15:0];
    endtask

    task automatic pulse_done();
        @(negedge clk);
        init_done = 1'b1;
        @(negedge clk);
        init_done = 1'b0;
        if (minit && !mdone) mdone = 1;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        model_reset();
    endtask

    task automatic rand_ptr();
        for (int i = 0; i < NP; i++) ptr_in[i*32 +: 32] = $urandom;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        mlo = '0; mhi = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // seed address registers while halted
        wr(2'd1, 32'h0000_0000);
        wr(2'd2, 32'h0000_0000);
        check_all("reset R1");

        // R9: alignment bits and reserved bits
        wr(2'd1, 32'hFFFF_BEEF);
        wr(2'd2, 32'hA5A5_12AB);
        check_all("R9 align");
        check("R9 lo low bits", {30'd0, init_addr[1:0]}, 32'd0);

        // R6: run plus init together waits for completion
        wr(2'd0, 32'h3);
        check_all("R6 both set");
        check("R6 not yet enabled", {31'd0, start_en}, 32'd0);
        pulse_done();
        check_all("R5 done accepted");
        check("R6 enabled after done", {31'd0, start_en}, 32'd1);
        check("R5 init stays", exp_ctrl() & 32'h1, 32'h1);

        // R7: locked while running
        wr(2'd1, 32'h0000_4444);
        wr(2'd2, 32'h0000_7777);
        check_all("R7 locked");
        check("R7 lo kept", {16'd0, init_addr[15:0]}, 32'h0000_BEEC);

        // R7: spnd unlocks
        spnd = 1'b1;
        wr(2'd2, 32'h0000_C3D4);
        spnd = 1'b0;
        check_all("R7 spnd unlock");

        // R3: zero write
        wr(2'd0, 32'h0);
        check_all("R3 zero write");

        // R2: halt with run wins
        wr(2'd0, 32'h6);
        check_all("R2 halt wins");
        check("R2 halt set", exp_ctrl(), 32'h4);

        // R4 and R6: run alone
        wr(2'd0, 32'h2);
        check_all("R4 R6 run alone");
        check("R6 immediate", {31'd0, start_en}, 32'd1);

        // R8: soft reset and hard reset keep addresses
        pulse_soft();
        check_all("R8 soft reset");
        wr(2'd0, 32'h1);
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R8 hard reset");

        // R10: both modes
        rand_ptr();
        struct32 = 1'b0;
        check_all("R10 24-bit");
        struct32 = 1'b1;
        check_all("R10 32-bit");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom % 8;
            case (op)
                0: wr(2'd0, ($urandom % 3 == 0) ? ($urandom & 32'h7)
                                                : (32'h1 << ($urandom % 3)));
                1: wr(2'd1, $urandom);
                2: wr(2'd2, $urandom);
                3: begin @(negedge clk); spnd = $urandom % 2; end
                4: pulse_done();
                5: if ($urandom % 4 == 0) pulse_soft(); else @(negedge clk);
                6: begin @(negedge clk); struct32 = $urandom % 2; rand_ptr(); end
                default: wr(2'd3, $urandom);
            endcase
            check_all("random");
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule